// File: doc/BRIEF.md
# Half-Bridge PWM Generator with Split Deadtime

This block drives one half-bridge power stage from a 16-bit signed time base. The counter runs from a programmable start value up to a programmable end value and then wraps. Each output is high while the counter is inside a window set by its own rising and falling compare values. Edge-aligned, center-aligned and asymmetrical waveforms therefore come from the choice of compare values alone. The two outputs either form a complementary high-side/low-side pair, with separate guard delays before each side turns on, or run as two independent channels.

Software programs the block through a single-cycle write port. The start, end, compare and trigger values sit in a shadow bank. The shadow bank moves into the active bank only after a load-enable flag is set, and then only on a programmable reload boundary. Fault pins pass through digital filters and latch both outputs at their inactive level. Per-output polarity, a software force, an external restart input and an ADC trigger strobe complete the block.

Top module: `pwm_halfbridge`

## Requirements
- R1: The counter is signed and runs from the active start value to the active end value one step per clock, then returns to the start value, so the period is end-start+1 cycles. While the run bit (control bit 0) is clear, the counter holds at the start value.
- R2: Output A's request is high when rise_a <= count < fall_a (signed compare). Each pin shows, one clock later, the level that the count of the previous cycle produces.
- R3: In complementary mode (control bit 1 clear), the bottom request is the inverse of A. The top output rises only after its request has been high for top-delay cycles (address 8), and the bottom output only after bottom-delay cycles (address 9). Both outputs are never active together.
- R4: In independent mode (control bit 1 set), output B follows its own window rise_b <= count < fall_b (addresses 4 and 5), and no delay is inserted on either output.
- R5: Addresses 0 to 7 (start, end, rise_a, fall_a, rise_b, fall_b, trig0, trig1) write a shadow bank. A write of 1 to address 11 sets a load flag. The shadow moves to the active bank only while the flag is set: at once while stopped, otherwise when the end value is reached in every N-th period, with N-1 in control bits 10:7. The flag clears on transfer.
- R6: With control bit 11 set, a transfer is also allowed when the count equals the signed midpoint (start+end)>>1.
- R7: A fault input's filtered value changes only after the raw pin has differed from it for L consecutive clocks, with L in bits 3:0 of address 12 (0 counts as 1). A shorter pulse has no effect.
- R8: A filtered fault that is enabled in its mask bit (address 12, bit 4+i) latches the fault. The latched fault drives each pin to its inactive level, which equals its polarity bit. A write to address 13 arms a clear, which takes effect at the next period end only if no enabled filtered fault is high. Each period end consumes the armed clear.
- R9: Each pin is its level XOR its polarity bit (bit 2 for top, bit 3 for bottom). With bit 4 set, the levels come from bits 5 and 6 instead of the counter. A fault overrides the force.
- R10: A high sync_in while running returns the counter to the start value on the next clock.
- R11: While running, adc_trig pulses for one cycle, one clock after the count equals trig0 or trig1.
- R12: While reset is held, both pins and adc_trig are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| fault_in | input | N_FAULT | Raw fault pins, active high |
| sync_in | input | 1 | Counter restart request |
| pwm_top | output | 1 | High-side output pin |
| pwm_bot | output | 1 | Low-side output pin |
| adc_trig | output | 1 | ADC trigger strobe |

## Verification
A counter value k cycles after the start write shows up on the pins and on the trigger at start+k+1. Every expected item is therefore stamped with that absolute cycle, pushed into a queue, and compared by a monitor at the falling edge of exactly that cycle. A fault becomes visible L+1 clocks after the pin rises. A reload becomes visible from the first count after the qualifying boundary, so checks sit on trigger cycles that differ between correct and wrong reload timing. Sync, filter and clear checks use the same stamping relative to the cycle of the stimulus.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int CW = 16;

    typedef logic signed [CW-1:0] cval_t;

    // field i of the bank sits at bits i*CW (start is index 0)
    typedef struct packed {
        cval_t trg1;
        cval_t trg0;
        cval_t b_off;
        cval_t b_on;
        cval_t a_off;
        cval_t a_on;
        cval_t modv;
        cval_t init;
    } bank_t;

    typedef struct packed {
        logic       half;
        logic [3:0] rld_m1;
        logic       frc_b;
        logic       frc_a;
        logic       frc_en;
        logic       pol_b;
        logic       pol_a;
        logic       indep;
        logic       run;
    } ctrl_t;

    localparam logic [3:0] A_DT_TOP = 4'd8;
    localparam logic [3:0] A_DT_BOT = 4'd9;
    localparam logic [3:0] A_CTRL   = 4'd10;
    localparam logic [3:0] A_LDOK   = 4'd11;
    localparam logic [3:0] A_FCFG   = 4'd12;
    localparam logic [3:0] A_FCLR   = 4'd13;

    function automatic logic in_win(cval_t c, cval_t on, cval_t off);
        return ($signed(c) >= $signed(on)) && ($signed(c) < $signed(off));
    endfunction

    function automatic bank_t bank_put(bank_t b, logic [2:0] idx, cval_t v);
        bank_t r;
        r = b;
        r[int'(idx)*CW +: CW] = v;
        return r;
    endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       sync_i,
    input  logic       ldok_i,
    input  logic       half_i,
    input  logic [3:0] rld_m1_i,
    input  bank_t      shadow_i,
    output bank_t      act_o,
    output cval_t      cnt_o,
    output logic       pe_o,
    output logic       rld_o
);
    bank_t act_q, nxt;
    cval_t cnt_q, mid;
    logic [3:0] cc_q;
    logic signed [CW:0] sum;
    logic cyc_hit, mid_hit;

    always_comb begin
        sum     = {act_q.init[CW-1], act_q.init} + {act_q.modv[CW-1], act_q.modv};
        mid     = sum[CW:1];
        pe_o    = run_i && (cnt_q == act_q.modv);
        cyc_hit = pe_o && (cc_q == rld_m1_i);
        mid_hit = run_i && half_i && (cnt_q == mid);
        rld_o   = ldok_i && (!run_i || cyc_hit || mid_hit);
        nxt     = rld_o ? shadow_i : act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
            cc_q  <= '0;
        end else begin
            act_q <= nxt;
            if (!run_i) begin
                cnt_q <= nxt.init;
                cc_q  <= '0;
            end else begin
                if (sync_i)    cnt_q <= act_q.init;
                else if (pe_o) cnt_q <= nxt.init;
                else           cnt_q <= cnt_q + cval_t'(1);
                if (pe_o) cc_q <= cyc_hit ? 4'd0 : cc_q + 4'd1;
            end
        end
    end

    assign act_o = act_q;
    assign cnt_o = cnt_q;

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (run_i && !sync_i && !pe_o) |=> (cnt_q == $past(cnt_q) + cval_t'(1)));
    p_sync_r10: assert property (@(posedge clk) disable iff (rst)
        (run_i && sync_i) |=> (cnt_q == $past(act_q.init)));
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            out_o
);
    logic [DT_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst || !req_i)   age_q <= '0;
        else if (age_q != '1) age_q <= age_q + DT_W'(1);
    end

    assign out_o = req_i && (age_q >= dt_i);
endmodule

// File: rtl/pwm_fault_filter.sv
module pwm_fault_filter #(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic [FLT_W-1:0] len_i,
    output logic             filt_o
);
    logic [FLT_W-1:0] c_q;
    logic             f_q;
    logic [FLT_W:0]   thr, inc;

    always_comb begin
        thr = (len_i == '0) ? (FLT_W+1)'(1) : {1'b0, len_i};
        inc = {1'b0, c_q} + (FLT_W+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
            f_q <= 1'b0;
        end else if (raw_i == f_q) begin
            c_q <= '0;
        end else if (inc >= thr) begin
            f_q <= raw_i;
            c_q <= '0;
        end else begin
            c_q <= c_q + FLT_W'(1);
        end
    end

    assign filt_o = f_q;

    p_filt_follow_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(f_q) |-> (f_q == $past(raw_i)));
endmodule

// File: rtl/pwm_halfbridge.sv
module pwm_halfbridge
    import pwm_pkg::*;
#(
    parameter int DT_W    = 8,
    parameter int FLT_W   = 4,
    parameter int N_FAULT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [CW-1:0]      wr_data,
    input  logic [N_FAULT-1:0] fault_in,
    input  logic               sync_in,
    output logic               pwm_top,
    output logic               pwm_bot,
    output logic               adc_trig
);
    localparam int MASK_LSB = 4;

    bank_t              shadow_q, act;
    ctrl_t              ctrl_q;
    logic [DT_W-1:0]    dt_top_q, dt_bot_q;
    logic [FLT_W-1:0]   flt_len_q;
    logic [N_FAULT-1:0] flt_mask_q, filt;
    logic               ldok_q, clr_q, latched_q;
    cval_t              cnt;
    logic               pe, rld, any_f, fault_act;
    logic               raw_a, raw_b, dt_top_o, dt_bot_o, lvl_a, lvl_b;
    logic               wr_ldok, wr_clr;

    assign wr_ldok = wr_en && (wr_addr == A_LDOK) && wr_data[0];
    assign wr_clr  = wr_en && (wr_addr == A_FCLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= '0;
            ctrl_q     <= '0;
            dt_top_q   <= '0;
            dt_bot_q   <= '0;
            flt_len_q  <= '0;
            flt_mask_q <= '0;
            ldok_q     <= 1'b0;
        end else begin
            if (wr_en) begin
                if (!wr_addr[3]) shadow_q <= bank_put(shadow_q, wr_addr[2:0], cval_t'(wr_data));
                case (wr_addr)
                    A_DT_TOP: dt_top_q <= wr_data[DT_W-1:0];
                    A_DT_BOT: dt_bot_q <= wr_data[DT_W-1:0];
                    A_CTRL:   ctrl_q   <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
                    A_FCFG: begin
                        flt_len_q  <= wr_data[FLT_W-1:0];
                        flt_mask_q <= wr_data[MASK_LSB +: N_FAULT];
                    end
                    default: ;
                endcase
            end
            if (wr_ldok)  ldok_q <= 1'b1;
            else if (rld) ldok_q <= 1'b0;
        end
    end

    pwm_timebase u_tb (
        .clk(clk), .rst(rst), .run_i(ctrl_q.run), .sync_i(sync_in),
        .ldok_i(ldok_q), .half_i(ctrl_q.half), .rld_m1_i(ctrl_q.rld_m1),
        .shadow_i(shadow_q), .act_o(act), .cnt_o(cnt), .pe_o(pe), .rld_o(rld)
    );

    for (genvar i = 0; i < N_FAULT; i++) begin : g_flt
        pwm_fault_filter #(.FLT_W(FLT_W)) u_flt (
            .clk(clk), .rst(rst), .raw_i(fault_in[i]), .len_i(flt_len_q), .filt_o(filt[i])
        );
    end

    assign any_f     = |(filt & flt_mask_q);
    assign fault_act = latched_q | any_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched_q <= 1'b0;
            clr_q     <= 1'b0;
        end else begin
            if (any_f)             latched_q <= 1'b1;
            else if (clr_q && pe)  latched_q <= 1'b0;
            if (wr_clr)   clr_q <= 1'b1;
            else if (pe)  clr_q <= 1'b0;
        end
    end

    assign raw_a = in_win(cnt, act.a_on, act.a_off);
    assign raw_b = in_win(cnt, act.b_on, act.b_off);

    pwm_deadtime #(.DT_W(DT_W)) u_dt_top (
        .clk(clk), .rst(rst), .req_i(raw_a), .dt_i(dt_top_q), .out_o(dt_top_o)
    );
    pwm_deadtime #(.DT_W(DT_W)) u_dt_bot (
        .clk(clk), .rst(rst), .req_i(!raw_a), .dt_i(dt_bot_q), .out_o(dt_bot_o)
    );

    always_comb begin
        lvl_a = ctrl_q.indep ? raw_a : dt_top_o;
        lvl_b = ctrl_q.indep ? raw_b : dt_bot_o;
        if (ctrl_q.frc_en) begin
            lvl_a = ctrl_q.frc_a;
            lvl_b = ctrl_q.frc_b;
        end
        if (fault_act) begin
            lvl_a = 1'b0;
            lvl_b = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_top  <= 1'b0;
            pwm_bot  <= 1'b0;
            adc_trig <= 1'b0;
        end else begin
            pwm_top  <= lvl_a ^ ctrl_q.pol_a;
            pwm_bot  <= lvl_b ^ ctrl_q.pol_b;
            adc_trig <= ctrl_q.run && ((cnt == act.trg0) || (cnt == act.trg1));
        end
    end

    p_pair_gap_r3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.indep |-> !(dt_top_o && dt_bot_o));
    p_ldok_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (rld && !wr_ldok) |=> !ldok_q);
    p_fault_safe_r8: assert property (@(posedge clk) disable iff (rst)
        fault_act |=> (pwm_top == $past(ctrl_q.pol_a)) && (pwm_bot == $past(ctrl_q.pol_b)));
endmodule

// File: tb/sim_pwm_halfbridge.sv
module sim_pwm_halfbridge;
    import pwm_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [NF-1:0] fault_in = '0;
    logic sync_in = 1'b0;
    logic pwm_top, pwm_bot, adc_trig;

    int cyc = 0;
    int t0 = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } item_t;
    item_t q[$];

    pwm_halfbridge #(.N_FAULT(NF)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_in(fault_in), .sync_in(sync_in),
        .pwm_top(pwm_top), .pwm_bot(pwm_bot), .adc_trig(adc_trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: got %b expected %b", req, cyc, act, exp);
        end
    endtask

    // monitor: compares every queued item at its due cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                case (q[i].sig)
                    0:       chk(q[i].req, pwm_top, q[i].val);
                    1:       chk(q[i].req, pwm_bot, q[i].val);
                    default: chk(q[i].req, adc_trig, q[i].val);
                endcase
                q.delete(i);
            end else if (q[i].at < cyc) begin
                n_run++;
                n_fail++;
                $display("FAIL %s item for cycle %0d missed: got x expected %b", q[i].req, q[i].at, q[i].val);
                q.delete(i);
            end
        end
    end

    task automatic push(int at, int sig, logic val, string req);
        item_t it;
        it.at = at; it.sig = sig; it.val = val; it.req = req;
        q.push_back(it);
    endtask

    task automatic push_pins(int at, logic a, logic b, string req);
        push(at, 0, a, req);
        push(at, 1, b, req);
    endtask

    task automatic wait_all();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int mk_ctrl(bit run, bit indep, bit pa, bit pb, bit fe,
                                   bit fa, bit fb, int rm1, bit half);
        return (int'(half) << 11) | ((rm1 & 15) << 7) | (int'(fb) << 6) | (int'(fa) << 5)
             | (int'(fe) << 4) | (int'(pb) << 3) | (int'(pa) << 2) | (int'(indep) << 1) | int'(run);
    endfunction

    // stop, load a full bank through the load flag, then start; t0 = start capture cycle
    task automatic cfg_start(int ini, int mo, int aon, int aoff, int bon, int boff,
                             int tg0, int tg1, int ctrl_run);
        wr(A_CTRL, ctrl_run & ~1);
        wr(4'd0, ini); wr(4'd1, mo); wr(4'd2, aon); wr(4'd3, aoff);
        wr(4'd4, bon); wr(4'd5, boff); wr(4'd6, tg0); wr(4'd7, tg1);
        wr(A_LDOK, 1);
        wr(A_CTRL, ctrl_run);
        t0 = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12 top in reset", pwm_top, 1'b0);
        chk("R12 bot in reset", pwm_bot, 1'b0);
        chk("R12 trig in reset", adc_trig, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R11: complementary, period 16, top delay 2, bottom delay 3
        wr(A_DT_TOP, 2);
        wr(A_DT_BOT, 3);
        cfg_start(-8, 7, -4, 4, 0, 0, -5, 100, mk_ctrl(1,0,0,0,0,0,0,0,0));
        for (int k = 16; k < 32; k++)
            push_pins(t0 + k + 1, (k >= 22 && k <= 27), (k <= 19 || k == 31), "R3 complementary deadtime");
        push(t0 + 19, 2, 1'b0, "R11 trig before match");
        push(t0 + 20, 2, 1'b1, "R11 trig at count -5");
        push(t0 + 21, 2, 1'b0, "R11 trig one cycle");
        push(t0 + 36, 2, 1'b1, "R1 period of 16");
        wait_all();

        // R4 R2: independent edge-aligned outputs with overlap, deadtime ignored
        cfg_start(-8, 7, -8, 0, -2, 6, -5, 100, mk_ctrl(1,1,0,0,0,0,0,0,0));
        for (int k = 16; k < 32; k++)
            push_pins(t0 + k + 1, (k - 16) < 8, ((k - 16) >= 6 && (k - 16) < 14), "R4 independent windows");
        wait_all();

        // R5: shadow write without load flag has no effect
        cfg_start(-8, 7, 0, 0, 0, 0, -5, 100, mk_ctrl(1,1,0,0,0,0,0,0,0));
        wr(4'd0, -4);
        push(t0 + 20, 2, 1'b1, "R5 no load flag keeps start");
        push(t0 + 36, 2, 1'b1, "R5 no load flag keeps start");
        wait_all();

        // R5 R1: reload every 2nd period
        cfg_start(-8, 7, 0, 0, 0, 0, -5, 100, mk_ctrl(1,1,0,0,0,0,0,1,0));
        wr(4'd1, 3);
        wr(A_LDOK, 1);
        push(t0 + 20, 2, 1'b1, "R5 old period kept in period 1");
        push(t0 + 36, 2, 1'b1, "R5 no reload after period 0");
        push(t0 + 48, 2, 1'b1, "R5 new period 12 after 2nd boundary");
        push(t0 + 52, 2, 1'b0, "R5 old period gone");
        wait_all();

        // R6: half-cycle reload at the midpoint -1
        cfg_start(-8, 7, 0, 0, 0, 0, -5, 100, mk_ctrl(1,1,0,0,0,0,0,0,1));
        wr(4'd6, 5);
        wr(A_LDOK, 1);
        push(t0 + 4, 2, 1'b1, "R6 old trigger before midpoint");
        push(t0 + 14, 2, 1'b1, "R6 new trigger after midpoint");
        push(t0 + 20, 2, 1'b0, "R6 old trigger gone");
        wait_all();

        // R10: sync restart
        cfg_start(-8, 7, 0, 0, 0, 0, -5, 100, mk_ctrl(1,1,0,0,0,0,0,0,0));
        while (cyc < t0 + 9) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        push(t0 + 14, 2, 1'b1, "R10 restart from start value");
        push(t0 + 20, 2, 1'b0, "R10 old phase gone");
        push(t0 + 30, 2, 1'b1, "R10 next period after restart");
        wait_all();

        // R9: force and polarity
        wr(A_CTRL, mk_ctrl(1,1,1,1,1,1,0,0,0));
        push_pins(cyc + 2, 1'b0, 1'b1, "R9 force with polarity");
        wait_all();
        wr(A_CTRL, mk_ctrl(1,1,0,0,1,0,1,0,0));
        push_pins(cyc + 2, 1'b0, 1'b1, "R9 force plain");
        wait_all();

        // R7 R8 R9: fault filter, mask, latch, clear; normal A=1 B=0, safe A=0 B=1
        wr(A_FCFG, 3 | (1 << 4));
        cfg_start(-8, 7, 0, 0, 0, 0, 100, 100, mk_ctrl(1,1,0,1,1,1,1,0,0));
        push_pins(cyc + 2, 1'b1, 1'b0, "R9 normal before fault");
        wait_all();
        begin
            int c;
            c = cyc;
            fault_in[0] = 1'b1;
            @(negedge clk); @(negedge clk);
            fault_in[0] = 1'b0;
            for (int j = 3; j < 8; j++) push_pins(c + j, 1'b1, 1'b0, "R7 short pulse ignored");
            wait_all();
            fault_in[1] = 1'b1;
            c = cyc;
            for (int j = 2; j < 8; j++) push_pins(c + j, 1'b1, 1'b0, "R8 masked input ignored");
            wait_all();
            fault_in[1] = 1'b0;
            @(negedge clk);
            c = cyc;
            fault_in[0] = 1'b1;
            push_pins(c + 3, 1'b1, 1'b0, "R7 not yet filtered");
            push_pins(c + 4, 1'b0, 1'b1, "R7 R9 fault overrides force");
            push_pins(c + 10, 1'b0, 1'b1, "R8 fault held");
            wait_all();
            wr(A_FCLR, 1);
            c = cyc;
            push_pins(c + 40, 1'b0, 1'b1, "R8 clear refused while active");
            wait_all();
            fault_in[0] = 1'b0;
            c = cyc;
            push_pins(c + 20, 1'b0, 1'b1, "R8 latch holds after release");
            wait_all();
            wr(A_FCLR, 1);
            c = cyc;
            push_pins(c + 1, 1'b0, 1'b1, "R8 clear waits for period end");
            push_pins(c + 20, 1'b1, 1'b0, "R8 cleared at period end");
            wait_all();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule